// File: doc/BRIEF.md
# Inverted-LSB-First Serial Word Loader

This block programs an external frequency synthesizer over three wires: a serial clock, an enable and a data line. A start request captures an 18-bit control word made of four fields: a 14-bit divider setting, a pump-current select bit, a standard-select bit and a 2-bit band code. The block then shifts the word out, least significant bit first, with every bit inverted on the line. When the word is complete it drops enable, which makes the receiver latch the word, and it raises a one-cycle done flag.

The receiver takes one bit on each falling serial-clock edge while enable is high. The block therefore changes the data line only together with a rising serial-clock edge. A half serial period is `HALF_DIV` system clocks long, so the serial rate is set by a parameter. While a transfer is running, `busy_o` is high and further start requests are ignored.

Top module: `serial_word_loader`

## Requirements
- R1: The word has the divider in bits 0 to 13, the pump-current select in bit 14, the standard select in bit 15, and band code bits 0 and 1 in bits 16 and 17. Bit 0 is sent first.
- R2: Every bit is driven inverted on `ser_data_o`: a logical 1 appears as low and a logical 0 as high.
- R3: The bits leave in ascending order. A divider of 9186 gives the first fourteen line levels H L H H H L L L L L H H H L.
- R4: Each transfer has exactly 18 falling serial-clock edges while enable is high.
- R5: `ser_clk_o` is high only while `ser_en_o` is high.
- R6: `ser_data_o` changes only together with a rising serial-clock edge. It holds its value for the whole high phase of the serial clock.
- R7: Enable rises `HALF_DIV` system cycles before the first rising serial-clock edge. Enable falls `HALF_DIV` cycles after the 18th falling edge.
- R8: A start request while `busy_o` is high has no effect on the word sent or on the number of frames. `busy_o` stays high until enable is low.
- R9: `done_o` is a one-cycle pulse. It rises in the same cycle that enable falls and `busy_o` drops.
- R10: Consecutive rising serial-clock edges are exactly `2*HALF_DIV` system cycles apart.
- R11: During reset and right after it, `ser_clk_o`, `ser_en_o`, `busy_o` and `done_o` are low and `ser_data_o` is high. A reset in the middle of a frame returns the outputs to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, taken when idle |
| divider_i | input | 14 | Divider setting |
| pump_hi_i | input | 1 | Pump-current select (1 = tenfold current) |
| norm_i | input | 1 | Standard-select bit |
| band_i | input | 2 | Band code |
| ser_clk_o | output | 1 | Serial clock, idles low |
| ser_en_o | output | 1 | Serial enable, idles low |
| ser_data_o | output | 1 | Inverted serial data, idles high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach from the ports is a second start request that arrives in the middle of a frame. The design must neither restart nor change the word it is sending. The bench raises `start_i` with a different word partway through a transfer. A receiver model in the bench checks that the latched word is still the first one and that only one frame was latched. The model also times every enable and clock edge, which exposes off-by-one errors in the half-period counter and in the tail after the last falling edge.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } swl_state_t;
endpackage

// File: rtl/swl_tick_gen.sv
module swl_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == CNT_MAX) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == CNT_MAX);

  // R10: the counter never passes the half-period limit
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
endmodule

// File: rtl/swl_word_pack.sv
module swl_word_pack #(
  parameter int DIV_W  = 14,
  parameter int BAND_W = 2,
  localparam int WORD_W = DIV_W + 2 + BAND_W
) (
  input  logic [DIV_W-1:0]  divider,
  input  logic              pump_hi,
  input  logic              norm,
  input  logic [BAND_W-1:0] band,
  output logic [WORD_W-1:0] line_word
);
  logic [WORD_W-1:0] logical_word;

  assign logical_word = {band, norm, pump_hi, divider};

  for (genvar g = 0; g < WORD_W; g++) begin : g_inv
    assign line_word[g] = ~logical_word[g];
  end
endmodule

// File: rtl/swl_shifter.sv
module swl_shifter
  import swl_pkg::*;
#(
  parameter int WORD_W = 18,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] line_word,
  input  logic              tick,
  output logic              load,
  output logic              ser_clk,
  output logic              ser_en,
  output logic              ser_data,
  output logic              busy,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  swl_state_t        state;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;

  assign load = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      idx      <= '0;
      ser_clk  <= 1'b0;
      ser_en   <= 1'b0;
      ser_data <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (load) begin
            state  <= ST_LEAD;
            shreg  <= line_word;
            idx    <= '0;
            ser_en <= 1'b1;
            busy   <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state    <= ST_SHIFT;
            ser_clk  <= 1'b1;
            ser_data <= shreg[0];
            shreg    <= shreg >> 1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (ser_clk) begin
              ser_clk <= 1'b0;
              if (idx == LAST_IDX) state <= ST_TAIL;
            end else begin
              ser_clk  <= 1'b1;
              ser_data <= shreg[0];
              shreg    <= shreg >> 1;
              idx      <= idx + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state    <= ST_IDLE;
            ser_en   <= 1'b0;
            ser_data <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: serial clock only inside enable
  a_r5_clk_in_enable: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> ser_en);
  // R6: data holds over the whole high phase
  a_r6_data_held_high: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  // R8: busy covers enable
  a_r8_busy_covers_en: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> busy);
  // R8: a request while busy does not reload the shifter
  a_r8_no_reload: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_TAIL) |=> busy);
  // R9: done is a single-cycle pulse with enable already low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ser_en && !busy));
  // R4: bit index stays inside the word
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX);
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int DIV_W    = 14,
  parameter int BAND_W   = 2,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  divider_i,
  input  logic              pump_hi_i,
  input  logic              norm_i,
  input  logic [BAND_W-1:0] band_i,
  output logic              ser_clk_o,
  output logic              ser_en_o,
  output logic              ser_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WORD_W = DIV_W + 2 + BAND_W;

  logic [WORD_W-1:0] line_word;
  logic              tick;
  logic              load;

  swl_word_pack #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_pack (
    .divider   (divider_i),
    .pump_hi   (pump_hi_i),
    .norm      (norm_i),
    .band      (band_i),
    .line_word (line_word)
  );

  swl_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .run     (busy_o),
    .tick    (tick)
  );

  swl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .line_word (line_word),
    .tick      (tick),
    .load      (load),
    .ser_clk   (ser_clk_o),
    .ser_en    (ser_en_o),
    .ser_data  (ser_data_o),
    .busy      (busy_o),
    .done      (done_o)
  );

  // R11: idle line state whenever no transfer is running
  a_r11_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ser_clk_o && !ser_en_o && ser_data_o));
endmodule

// File: tb/test_serial_word_loader.sv
module test_serial_word_loader;
  localparam int HALF = 4;
  localparam int NW   = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [13:0] divider_i = '0;
  logic pump_hi_i = 1'b0, norm_i = 1'b0;
  logic [1:0] band_i = '0;
  logic ser_clk_o, ser_en_o, ser_data_o, busy_o, done_o;

  always #4 clk = ~clk;

  serial_word_loader #(.DIV_W(14), .BAND_W(2), .HALF_DIV(HALF)) i_serial_word_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .divider_i(divider_i),
    .pump_hi_i(pump_hi_i), .norm_i(norm_i), .band_i(band_i),
    .ser_clk_o(ser_clk_o), .ser_en_o(ser_en_o), .ser_data_o(ser_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // vectors: {band, norm, pump, divider}
  localparam logic [NW-1:0] VEC [6] = '{
    {2'b00, 1'b0, 1'b1, 14'd9186},
    {2'b00, 1'b0, 1'b0, 14'd0},
    {2'b11, 1'b1, 1'b1, 14'h3FFF},
    {2'b01, 1'b1, 1'b0, 14'h2AAA},
    {2'b10, 1'b0, 1'b1, 14'h1555},
    {2'b11, 1'b1, 1'b1, 14'd1}
  };

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic p_clk = 0, p_en = 0, p_data = 1;
  logic [NW-1:0] rx_raw = '0, lat_raw = '0;
  int nfall = 0, lat_n = 0, frames = 0, done_cnt = 0;
  int t_en_rise = 0, t_first_rise = 0, t_last_fall = 0, t_en_fall = 0, t_done = -1;
  int prev_rise = 0, gap_bad = 0, r5_bad = 0, r6_bad = 0, r8_bad = 0;
  logic first_seen = 0, busy_at_done = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // receiver model and timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ser_en_o && !busy_o) r8_bad++;
      if (ser_clk_o && !ser_en_o) r5_bad++;
      if (p_clk && ser_clk_o && ser_data_o != p_data) r6_bad++;
      if (!p_clk && !ser_clk_o && ser_data_o != p_data && ser_en_o && p_en) r6_bad++;
      if (ser_en_o && !p_en) begin
        t_en_rise = cyc; nfall = 0; first_seen = 0;
      end
      if (ser_clk_o && !p_clk) begin
        if (!first_seen) begin t_first_rise = cyc; first_seen = 1; end
        else if (cyc - prev_rise != 2*HALF) gap_bad++;
        prev_rise = cyc;
      end
      if (!ser_clk_o && p_clk && ser_en_o) begin
        if (nfall < NW) rx_raw[nfall] = ser_data_o;
        nfall++;
        t_last_fall = cyc;
      end
      if (!ser_en_o && p_en) begin
        lat_raw = rx_raw; lat_n = nfall; t_en_fall = cyc; frames++;
      end
      if (done_o) begin
        t_done = cyc; done_cnt++; busy_at_done = busy_o;
      end
    end
    p_clk = ser_clk_o; p_en = ser_en_o; p_data = ser_data_o;
  end

  task automatic drive(input logic [NW-1:0] w);
    divider_i = w[13:0]; pump_hi_i = w[14]; norm_i = w[15]; band_i = w[17:16];
  endtask

  task automatic wait_done(input int old);
    while (done_cnt == old) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic transfer(input logic [NW-1:0] w);
    int old;
    old = done_cnt;
    @(negedge clk);
    drive(w); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(old);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: state during reset
    check(!ser_clk_o && !ser_en_o && ser_data_o && !busy_o && !done_o, "R11 reset state",
          {ser_clk_o, ser_en_o, ser_data_o, busy_o, done_o}, 5'b00100);
    rst = 1'b0;
    @(negedge clk);
    check(!ser_clk_o && !ser_en_o && ser_data_o && !busy_o, "R11 after reset",
          {ser_clk_o, ser_en_o, ser_data_o, busy_o}, 4'b0010);

    for (int v = 0; v < 6; v++) begin
      logic [NW-1:0] w;
      int gb;
      w = VEC[v];
      gb = gap_bad;
      transfer(w);
      check(~lat_raw[13:0] == w[13:0], "R1 divider field", ~lat_raw[13:0], w[13:0]);
      check(~lat_raw[14] == w[14], "R1 pump bit", ~lat_raw[14], w[14]);
      check(~lat_raw[17:15] == w[17:15], "R1 norm/band bits", ~lat_raw[17:15], w[17:15]);
      check(lat_raw == ~w, "R2 inverted line levels", lat_raw, ~w);
      check(lat_n == NW, "R4 falling edges per frame", lat_n, NW);
      check(t_first_rise - t_en_rise == HALF, "R7 lead time", t_first_rise - t_en_rise, HALF);
      check(t_en_fall - t_last_fall == HALF, "R7 tail time", t_en_fall - t_last_fall, HALF);
      check(gap_bad == gb, "R10 clock period", gap_bad - gb, 0);
      check(t_done == t_en_fall && !busy_at_done, "R9 done with enable fall",
            t_done - t_en_fall, 0);
    end

    // R3: documented level pattern for divider 9186
    begin
      string pat;
      pat = "HLHHHLLLLLHHHL";
      transfer({2'b00, 1'b0, 1'b0, 14'd9186});
      for (int i = 0; i < 14; i++)
        check(lat_raw[i] == (pat[i] == "H"), "R3 level order", lat_raw[i], pat[i] == "H");
    end

    // R8: a second request mid-frame is ignored
    begin
      int old, fr;
      logic [NW-1:0] wa, wb;
      wa = {2'b01, 1'b0, 1'b1, 14'h0F0F};
      wb = {2'b10, 1'b1, 1'b0, 14'h30F0};
      old = done_cnt; fr = frames;
      @(negedge clk); drive(wa); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (20) @(negedge clk);
      drive(wb); start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
      wait_done(old);
      check(lat_raw == ~wa, "R8 word unchanged by late start", lat_raw, ~wa);
      check(frames == fr + 1, "R8 single frame", frames - fr, 1);
      check(done_cnt == old + 1, "R8 single done", done_cnt - old, 1);
      check(lat_n == NW, "R8 bit count", lat_n, NW);
    end

    // R11: reset in the middle of a frame
    @(negedge clk); drive(VEC[3]); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!ser_clk_o && !ser_en_o && ser_data_o && !busy_o, "R11 mid-frame reset",
          {ser_clk_o, ser_en_o, ser_data_o, busy_o}, 4'b0010);

    check(r5_bad == 0, "R5 clock outside enable", r5_bad, 0);
    check(r6_bad == 0, "R6 data change off rising edge", r6_bad, 0);
    check(r8_bad == 0, "R8 enable without busy", r8_bad, 0);
    finish_run();
  end
endmodule